// File: doc/BRIEF.md
# BCD Real-Time Calendar with Initialization Handshake

This block keeps the time of day (hours, minutes, seconds) and the calendar date (day of month, month, two-digit year, weekday) in packed BCD. It runs on a slow real-time clock. A two-stage divider makes one calendar step per second. The first stage is a short asynchronous divider that feeds the second stage, a longer synchronous divider.

Software reaches the block through a small word-addressed register port. Four words are visible: time, date, divider and status. To set the clock, software first raises the init request. It then waits for the acknowledge flag, which stops the calendar and the dividers. Only then can it load the time, date and divider words. Dropping the request starts counting again from a cleared divider.

Time and date reads come from shadow copies. A resync flag lets software see when those copies have caught up with the live calendar after an update.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00002101 (day 01, month 01, weekday 1, year 00), the divider word reads its parameter defaults (0x007F00FF with defaults), and the status bits for init request, acknowledge and initialised are 0.
- R2: Outside init mode, `tick_o` pulses for one cycle every (A+1)·(S+1) clock cycles. S is the synchronous divider in divider-word bits 14:0 and A is the asynchronous divider in bits 22:16.
- R3: Writing 1 to status bit 7 (init request) makes status bit 6 (acknowledge) read 1 from the second clock edge after the write. While the request is set, no tick occurs and the dividers are held cleared. The acknowledge drops one edge after the request is cleared.
- R4: A write to the time, date or divider word while the acknowledge is 0 leaves that word unchanged.
- R5: The time word holds BCD seconds in bits 6:0, BCD minutes in bits 14:8 and BCD hours (24-hour) in bits 21:16. On a tick, seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00 and advance the date.
- R6: The date word holds the BCD day in bits 5:0, the BCD month in bits 12:8 (tens digit in bit 12), the weekday in bits 15:13 and the BCD year in bits 23:16. On a day advance:
  - the weekday goes 1..7 and wraps 7→1 (1 is Monday);
  - the day wraps to 01 after the last day of the month, where April, June, September and November have 30 days, February has 29 days when the year is divisible by 4 (00 included) and 28 otherwise, and the other months have 31;
  - the month wraps 12→01, and the year wraps 99→00.
- R7: Status bit 5 (resync flag) is cleared by a status write with bit 5 at 0. It is set again on the second clock edge after that with the init request low, and it is never set while the request is high.
- R8: Time and date reads return a shadow copy that follows the live calendar one cycle late and is frozen while the init request is set.
- R9: Status bit 4 (initialised) reads 1 exactly when the live year is non-zero.
- R10: The status word carries only bits 7..4; all other bits read 0. A status write sets the init request to written bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Real-time clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 2 | Word select: 0 time, 1 date, 2 divider, 3 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word (combinational) |
| tick_o | output | 1 | One-cycle calendar step pulse |

## Verification
The calendar is loaded with instants just before each kind of rollover and then run with a two-cycle tick:
- minute and hour carries;
- the end of February in a leap year and in a common year;
- a 30-day month;
- the year 99 wrap, which also separates the weekday wrap and the initialised flag from the day logic.

The handshake is tried in three ways:
- entering and leaving init, checked cycle by cycle for the acknowledge delay;
- writes with the acknowledge low, which must leave the words alone;
- flag clears both inside and outside init, which separates the resync rule from the acknowledge.

The tick period is measured with a non-trivial divider pair, which separates the two divider stages.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam logic [1:0] ADDR_TIME = 2'd0;
  localparam logic [1:0] ADDR_DATE = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int STAT_INIT  = 7;
  localparam int STAT_ACK   = 6;
  localparam int STAT_RSF   = 5;
  localparam int STAT_INITD = 4;

  typedef struct packed {
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [5:0] day;
  } cal_date_t;

  localparam cal_time_t TIME_RST = '{hr: 6'h00, min: 7'h00, sec: 7'h00};
  localparam cal_date_t DATE_RST = '{yr: 8'h00, wday: 3'd1, mon: 5'h01, day: 6'h01};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_yr(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [31:0] time_word(input cal_time_t t);
    return {10'd0, t.hr, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic logic [31:0] date_word(input cal_date_t d);
    return {8'd0, d.yr, d.wday, d.mon, 2'b0, d.day};
  endfunction

  function automatic cal_time_t time_unpack(input logic [31:0] w);
    return '{hr: w[21:16], min: w[14:8], sec: w[6:0]};
  endfunction

  function automatic cal_date_t date_unpack(input logic [31:0] w);
    return '{yr: w[23:16], wday: w[15:13], mon: w[12:8], day: w[5:0]};
  endfunction

endpackage

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [S_W-1:0] div_s_i,
  output logic           tick_o
);
  logic [A_W-1:0] a_q;
  logic [S_W-1:0] s_q;
  logic a_wrap, s_wrap;

  assign a_wrap = (a_q == div_a_i);
  assign s_wrap = (s_q == div_s_i);
  assign tick_o = !hold_i && a_wrap && s_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      s_q <= '0;
    end else if (hold_i) begin
      a_q <= '0;
      s_q <= '0;
    end else if (a_wrap) begin
      a_q <= '0;
      s_q <= s_wrap ? '0 : s_q + 1'b1;
    end else begin
      a_q <= a_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_cal_initsync.sv
module rtc_cal_initsync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_wr_i,
  input  logic init_d_i,
  input  logic rsf_keep_i,
  output logic init_o,
  output logic ack_o,
  output logic rsf_o
);
  logic init_q, stage_q, ack_q, rsf_q, rs_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b0;
      stage_q  <= 1'b0;
      ack_q    <= 1'b0;
      rsf_q    <= 1'b0;
      rs_cnt_q <= 1'b0;
    end else begin
      if (stat_wr_i) init_q <= init_d_i;
      stage_q <= init_q;
      ack_q   <= stage_q && init_q;
      if (stat_wr_i && !rsf_keep_i) begin
        rsf_q    <= 1'b0;
        rs_cnt_q <= 1'b0;
      end else if (!rsf_q && !init_q) begin
        if (rs_cnt_q) rsf_q <= 1'b1;
        else          rs_cnt_q <= 1'b1;
      end
    end
  end

  assign init_o = init_q;
  assign ack_o  = ack_q;
  assign rsf_o  = rsf_q;
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      ld_time_i,
  input  logic      ld_date_i,
  input  cal_time_t time_d_i,
  input  cal_date_t date_d_i,
  output cal_time_t time_o,
  output cal_date_t date_o
);
  cal_time_t t_q, t_n;
  cal_date_t d_q, d_n;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    t_n = t_q;
    d_n = d_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    if (tick_i) begin
      if (t_q.sec == 7'h59) begin t_n.sec = '0; c_min = 1'b1; end
      else t_n.sec = 7'(bcd_inc({1'b0, t_q.sec}));
    end
    if (c_min) begin
      if (t_q.min == 7'h59) begin t_n.min = '0; c_hr = 1'b1; end
      else t_n.min = 7'(bcd_inc({1'b0, t_q.min}));
    end
    if (c_hr) begin
      if (t_q.hr == 6'h23) begin t_n.hr = '0; c_day = 1'b1; end
      else t_n.hr = 6'(bcd_inc({2'b0, t_q.hr}));
    end
    if (c_day) begin
      d_n.wday = (d_q.wday == 3'd7) ? 3'd1 : d_q.wday + 3'd1;
      if (d_q.day == last_day(d_q.mon, d_q.yr)) begin d_n.day = 6'h01; c_mon = 1'b1; end
      else d_n.day = 6'(bcd_inc({2'b0, d_q.day}));
    end
    if (c_mon) begin
      if (d_q.mon == 5'h12) begin d_n.mon = 5'h01; c_yr = 1'b1; end
      else d_n.mon = 5'(bcd_inc({3'b0, d_q.mon}));
    end
    if (c_yr) d_n.yr = (d_q.yr == 8'h99) ? 8'h00 : bcd_inc(d_q.yr);
    if (ld_time_i) t_n = time_d_i;
    if (ld_date_i) d_n = date_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= TIME_RST;
      d_q <= DATE_RST;
    end else begin
      t_q <= t_n;
      d_q <= d_n;
    end
  end

  assign time_o = t_q;
  assign date_o = d_q;
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        tick_o
);
  localparam int A_LSB = 16;

  logic init, ack, rsf, tick;
  logic [A_W-1:0] div_a_q;
  logic [S_W-1:0] div_s_q;
  cal_time_t cal_time, sh_time_q;
  cal_date_t cal_date, sh_date_q;
  logic wr_time, wr_date, wr_div, wr_stat;

  assign wr_time = wr_i && addr_i == ADDR_TIME && ack;
  assign wr_date = wr_i && addr_i == ADDR_DATE && ack;
  assign wr_div  = wr_i && addr_i == ADDR_DIV  && ack;
  assign wr_stat = wr_i && addr_i == ADDR_STAT;

  rtc_cal_initsync u_sync (
    .clk_i, .rst_ni,
    .stat_wr_i (wr_stat),
    .init_d_i  (wdata_i[STAT_INIT]),
    .rsf_keep_i(wdata_i[STAT_RSF]),
    .init_o    (init),
    .ack_o     (ack),
    .rsf_o     (rsf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_q <= A_W'(A_RST);
      div_s_q <= S_W'(S_RST);
    end else if (wr_div) begin
      div_a_q <= wdata_i[A_LSB +: A_W];
      div_s_q <= wdata_i[S_W-1:0];
    end
  end

  rtc_cal_prescaler #(.A_W(A_W), .S_W(S_W)) u_div (
    .clk_i, .rst_ni,
    .hold_i (init),
    .div_a_i(div_a_q),
    .div_s_i(div_s_q),
    .tick_o (tick)
  );

  rtc_cal_counter u_cal (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .ld_time_i(wr_time),
    .ld_date_i(wr_date),
    .time_d_i (time_unpack(wdata_i)),
    .date_d_i (date_unpack(wdata_i)),
    .time_o   (cal_time),
    .date_o   (cal_date)
  );

  // shadow copies for the bus, frozen during init
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_time_q <= TIME_RST;
      sh_date_q <= DATE_RST;
    end else if (!init) begin
      sh_time_q <= cal_time;
      sh_date_q <= cal_date;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_TIME: rdata_o = time_word(sh_time_q);
      ADDR_DATE: rdata_o = date_word(sh_date_q);
      ADDR_DIV: begin
        rdata_o[S_W-1:0]     = div_s_q;
        rdata_o[A_LSB +: A_W] = div_a_q;
      end
      default: begin
        rdata_o[STAT_INIT]  = init;
        rdata_o[STAT_ACK]   = ack;
        rdata_o[STAT_RSF]   = rsf;
        rdata_o[STAT_INITD] = (cal_date.yr != 8'h00);
      end
    endcase
  end

  assign tick_o = tick;
endmodule

module rtc_cal_top_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_i,
  input logic        ack_i,
  input logic        rsf_i,
  input logic        tick_i,
  input logic        wr_i,
  input logic [1:0]  addr_i,
  input logic [31:0] time_i,
  input logic [31:0] date_i
);
  assert_ack_after_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> init_i && $past(init_i));

  assert_no_tick_in_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> !tick_i);

  assert_locked_time_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0 && !ack_i && !tick_i) |=> $stable(time_i));

  assert_sec_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && time_i[6:0] == 7'h59) |=> time_i[6:0] == 7'h00);

  assert_wday_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && time_i[21:0] == 22'h235959) |=> date_i[15:13] != $past(date_i[15:13]));

  assert_rsf_outside_init_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsf_i) |-> !$past(init_i));
endmodule

bind rtc_cal_top rtc_cal_top_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .init_i (init),
  .ack_i  (ack),
  .rsf_i  (rsf),
  .tick_i (tick),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .time_i (rtc_cal_pkg::time_word(cal_time)),
  .date_i (rtc_cal_pkg::date_word(cal_date))
);

// File: tb/rtc_cal_top_tb_top.sv
module rtc_cal_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_cal_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  // ---------------- behavioural reference ----------------
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd;
  int s_sec, s_min, s_hr, s_day, s_mon, s_yr, s_wd;
  int m_pa, m_ps, m_ca, m_cs;
  bit m_init, m_stage, m_ack, m_rsf, m_rscnt;

  function automatic int to_bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int from_bcd(int v); return ((v >> 4) & 15) * 10 + (v & 15); endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] exp_word(logic [1:0] a);
    case (a)
      2'd0: return 32'((to_bcd(s_hr) << 16) | (to_bcd(s_min) << 8) | to_bcd(s_sec));
      2'd1: return 32'((to_bcd(s_yr) << 16) | (s_wd << 13) | (to_bcd(s_mon) << 8) | to_bcd(s_day));
      2'd2: return 32'((m_pa << 16) | m_ps);
      default: return 32'((m_init << 7) | (m_ack << 6) | (m_rsf << 5) | ((m_yr != 0) << 4));
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 1;
      s_sec = 0; s_min = 0; s_hr = 0; s_day = 1; s_mon = 1; s_yr = 0; s_wd = 1;
      m_pa = 127; m_ps = 255; m_ca = 0; m_cs = 0;
      m_init = 0; m_stage = 0; m_ack = 0; m_rsf = 0; m_rscnt = 0;
    end else begin
      bit tk, o_init, o_stage, o_ack;
      tk = !m_init && m_ca == m_pa && m_cs == m_ps;
      o_init = m_init; o_stage = m_stage; o_ack = m_ack;
      if (!o_init) begin
        s_sec = m_sec; s_min = m_min; s_hr = m_hr;
        s_day = m_day; s_mon = m_mon; s_yr = m_yr; s_wd = m_wd;
      end
      if (o_init) begin m_ca = 0; m_cs = 0; end
      else if (m_ca == m_pa) begin m_ca = 0; m_cs = (m_cs == m_ps) ? 0 : m_cs + 1; end
      else m_ca++;
      if (tk) begin
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
          m_hr = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_day++;
          if (m_day > mdays(m_mon, m_yr)) begin m_day = 1; m_mon++; end
          if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end
      end
      if (wr && o_ack && addr == 2'd0) begin
        m_sec = from_bcd(int'(wdata[6:0])); m_min = from_bcd(int'(wdata[14:8]));
        m_hr = from_bcd(int'(wdata[21:16]));
      end
      if (wr && o_ack && addr == 2'd1) begin
        m_day = from_bcd(int'(wdata[5:0])); m_mon = from_bcd(int'(wdata[12:8]));
        m_wd = int'(wdata[15:13]); m_yr = from_bcd(int'(wdata[23:16]));
      end
      if (wr && o_ack && addr == 2'd2) begin
        m_pa = int'(wdata[22:16]); m_ps = int'(wdata[14:0]);
      end
      if (wr && addr == 2'd3) m_init = wdata[7];
      m_stage = o_init;
      m_ack = o_stage && o_init;
      if (wr && addr == 2'd3 && !wdata[5]) begin m_rsf = 0; m_rscnt = 0; end
      else if (!m_rsf && !o_init) begin
        if (m_rscnt) m_rsf = 1; else m_rscnt = 1;
      end
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [31:0] e;
      bit et;
      e = exp_word(addr);
      et = !m_init && m_ca == m_pa && m_cs == m_ps;
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL R5/R6/R8/R10 stream addr=%0d actual=%h expected=%h", addr, rdata, e);
      end
      n_cmp++;
      if (tick !== et) begin
        n_bad++;
        $display("FAIL R2/R3 tick stream actual=%0b expected=%0b", tick, et);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_now(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic advance(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr = addr + 2'd1;
    end
  endtask

  task automatic set_cal(logic [31:0] tw, logic [31:0] dw, logic [31:0] pw);
    bus_write(2'd3, 32'h0000_00A0);
    advance(3);
    bus_write(2'd0, tw);
    bus_write(2'd1, dw);
    bus_write(2'd2, pw);
    bus_write(2'd3, 32'h0000_0020);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    advance(4);
    read_now(2'd0, r); chk("R1 time after reset", r, 32'h0000_0000);
    read_now(2'd1, r); chk("R1 date after reset", r, 32'h0000_2101);
    read_now(2'd2, r); chk("R1 divider after reset", r, 32'h007F_00FF);
    read_now(2'd3, r); chk("R1/R10 status after reset", r, 32'h0000_0020);

    // R4: locked writes ignored
    bus_write(2'd0, 32'h0012_3456);
    bus_write(2'd1, 32'h0099_2531);
    bus_write(2'd2, 32'h0000_0003);
    advance(2);
    read_now(2'd0, r); chk("R4 time write ignored", r, 32'h0000_0000);
    read_now(2'd1, r); chk("R4 date write ignored", r, 32'h0000_2101);
    read_now(2'd2, r); chk("R4 divider write ignored", r, 32'h007F_00FF);

    // R3: handshake timing
    bus_write(2'd3, 32'h0000_00A0);
    read_now(2'd3, r); chk("R3 ack low after first edge", r, 32'h0000_00A0);
    advance(1);
    read_now(2'd3, r); chk("R3 ack low after second edge", r, 32'h0000_00A0);
    advance(1);
    read_now(2'd3, r); chk("R3 ack high", r, 32'h0000_00E0);
    bus_write(2'd0, 32'h0023_5958);
    read_now(2'd0, r); chk("R8 shadow frozen in init", r, 32'h0000_0000);
    bus_write(2'd1, 32'h0024_6228);
    bus_write(2'd2, 32'h0000_0001);
    advance(4);
    read_now(2'd3, r); chk("R9 initialised with year 24", r, 32'h0000_00F0);
    chk("R3 no tick in init", {31'd0, tick}, 32'd0);
    bus_write(2'd3, 32'h0000_0020);
    advance(2);
    read_now(2'd0, r); chk("R8 shadow after exit", r & 32'h003F_7F00, 32'h0023_5900);
    advance(8);
    read_now(2'd1, r); chk("R6 leap Feb 28 -> 29, weekday 3 -> 4", r, 32'h0024_8229);
    read_now(2'd0, r); chk("R5 hour wrap 23 -> 00", r & 32'h003F_7F00, 32'h0000_0000);

    set_cal(32'h0023_5959, 32'h0024_8229, 32'h0000_0001);
    advance(8);
    read_now(2'd1, r); chk("R6 leap Feb 29 -> Mar 1", r, 32'h0024_A301);

    set_cal(32'h0023_5959, 32'h0023_E228, 32'h0000_0001);
    advance(8);
    read_now(2'd1, r); chk("R6 common Feb 28 -> Mar 1, weekday 7 -> 1", r, 32'h0023_2301);

    set_cal(32'h0023_5959, 32'h0007_4430, 32'h0000_0001);
    advance(8);
    read_now(2'd1, r); chk("R6 Apr 30 -> May 1", r, 32'h0007_6501);

    set_cal(32'h0009_5959, 32'h0007_6501, 32'h0000_0001);
    advance(8);
    read_now(2'd0, r); chk("R5 minute carry into hour", r & 32'h003F_7F00, 32'h0010_0000);

    set_cal(32'h0023_5959, 32'h0099_F231, 32'h0000_0001);
    advance(8);
    read_now(2'd1, r); chk("R6 year 99 -> 00", r, 32'h0000_2101);
    read_now(2'd3, r); chk("R9 initialised clears at year 00", r, 32'h0000_0020);

    // R2: tick period with A=1, S=2 -> 6 cycles
    set_cal(32'h0000_0000, 32'h0001_2101, 32'h0001_0002);
    begin
      int c, g;
      g = 0;
      do begin @(negedge clk); g++; end while (!tick && g < 100);
      c = 0;
      do begin @(negedge clk); c++; end while (!tick && c < 100);
      chk("R2 tick period", 32'(c), 32'd6);
    end
    read_now(2'd2, r); chk("R2 divider word layout", r, 32'h0001_0002);

    // R7: resync flag outside init
    bus_write(2'd3, 32'h0000_0000);
    read_now(2'd3, r); chk("R7 flag cleared", r & 32'h20, 32'h0);
    advance(1);
    read_now(2'd3, r); chk("R7 flag still low after one edge", r & 32'h20, 32'h0);
    advance(1);
    read_now(2'd3, r); chk("R7 flag set after two edges", r & 32'h20, 32'h20);

    // R7: not set while init held
    bus_write(2'd3, 32'h0000_0080);
    advance(6);
    read_now(2'd3, r); chk("R7 flag held low in init", r, 32'h0000_00D0);
    bus_write(2'd3, 32'h0000_0000);
    advance(1);
    read_now(2'd3, r); chk("R3 ack drops after exit", r & 32'hC0, 32'h0);
    advance(2);
    read_now(2'd3, r); chk("R7 flag set after exit", r & 32'h20, 32'h20);
    advance(20);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule